// File: doc/BRIEF.md
# Checksummed Frame Builder and Paced Bit Serializer

This block sits ahead of a bit-level modulator. It takes 16-bit payload words over a valid/ready handshake, wraps each word into a 24-bit frame and emits that frame one bit at a time. The frame opens with a constant all-ones nibble that lets a receiver find frame edges. The payload follows, and a 4-bit additive checksum closes the frame. Each emitted bit stays on the output for a fixed number of clock cycles, eight by default, which matches the symbol pacing the modulator expects.

Bit periods follow a free-running grid that starts when reset is released. The block asks for the next payload word only in the final cycle of a bit period, and only when it is idle or emitting the last bit of the current frame. A word offered while frames are streaming is therefore taken just as the previous frame ends, and the two frames join with no idle bit between them. When no word is waiting at a frame boundary, the line carries zeros, one bit period at a time, until a word arrives.

Top module: `pkt_framer_ser`

## Requirements
- R1: A frame is 24 bits with this layout: bits 23..20 hold the constant 4'b1111, bits 19..4 hold the accepted payload word unchanged, and bits 3..0 hold the checksum.
- R2: The checksum is the low 4 bits of the sum of 4'hF and the four payload nibbles (payload bits 15..12, 11..8, 7..4, 3..0). Any carry out of bit 3 is dropped.
- R3: Frame bits leave on `bit_out` starting with bit 23 and ending with bit 0, so the preamble comes first.
- R4: Every bit period lasts exactly 8 cycles and `bit_out` holds its value through the whole period. Periods sit on a fixed grid: the N-th rising edge after reset release ends a period when N mod 8 equals 0.
- R5: `pay_ready` is high only in the final cycle of a bit period, and then only if the block is idle or emitting frame bit 0. A word is accepted at a rising edge where `pay_valid` and `pay_ready` are both high.
- R6: The bit period that starts right after an accepting edge carries frame bit 23. When a word is accepted during the last bit of a frame, the next frame follows with no gap.
- R7: When no frame is in progress, `bit_out` is 0.
- R8: While reset is asserted, `bit_out` and `pay_ready` are both 0.
- R9: A word offered with `pay_valid` and withdrawn before `pay_ready` rises produces no frame, and `bit_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pay_data | input | 16 | Payload word to be framed |
| pay_valid | input | 1 | Payload word is offered |
| pay_ready | output | 1 | Block takes the offered word at this edge |
| bit_out | output | 1 | Serial frame bit toward the modulator |

## Verification
The critical overlap happens in one cycle: the final cycle of a frame's bit 0, when the shifter finishes the old frame and the loader takes the next word. The bench provokes it by keeping a new word on `pay_valid` across several consecutive frames. A scoreboard then checks that each frame it captures equals the independently computed frame and that the second frame's bit 23 lands in the very next bit period. The same boundary is also exercised with no word present, where the line must drop to zeros. A third case offers a word that is withdrawn before the boundary, and it must leave no trace on the output.

// File: rtl/framer_pkg.sv
package framer_pkg;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_SEND = 1'b1
  } fr_state_e;

  // Total frame width built from payload width and nibble width.
  function automatic int unsigned frame_bits(input int unsigned data_w,
                                             input int unsigned nib_w);
    return data_w + 2 * nib_w;
  endfunction

  // Safe counter width for a count limit of at least one.
  function automatic int unsigned count_bits(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/framer_pacer.sv
module framer_pacer #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_tick
);
  localparam int CNT_W = framer_pkg::count_bits(HOLD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

  logic [CNT_W-1:0] cnt;

  assign bit_tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (bit_tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/framer_csum.sv
module framer_csum #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  parameter logic [NIB_W-1:0] PREAMBLE = '1
) (
  input  logic [DATA_W-1:0] data,
  output logic [NIB_W-1:0]  sum
);
  localparam int NUM_NIB = DATA_W / NIB_W;

  logic [NIB_W-1:0] nib [NUM_NIB];

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
    assign nib[g] = data[g*NIB_W +: NIB_W];
  end

  // Modulo-2^NIB_W accumulation: carries fall off the top.
  always_comb begin
    sum = PREAMBLE;
    for (int i = 0; i < NUM_NIB; i++) begin
      sum = sum + nib[i];
    end
  end
endmodule

// File: rtl/framer_shifter.sv
module framer_shifter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               msb,
  output logic               last_bit
);
  localparam int IDX_W = framer_pkg::count_bits(FRAME_W);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;

  assign msb      = shreg[FRAME_W-1];
  assign last_bit = (idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      idx   <= '0;
    end else if (bit_tick) begin
      if (load) begin
        shreg <= frame_in;
        idx   <= TOP;
      end else if (!last_bit) begin
        shreg <= {shreg[FRAME_W-2:0], 1'b0};
        idx   <= idx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_framer_ser.sv
module pkt_framer_ser #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  parameter int HOLD   = 8,
  parameter logic [NIB_W-1:0] PREAMBLE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pay_data,
  input  logic              pay_valid,
  output logic              pay_ready,
  output logic              bit_out
);
  import framer_pkg::*;

  localparam int FRAME_W = frame_bits(DATA_W, NIB_W);

  fr_state_e          state;
  logic               bit_tick;
  logic               last_bit;
  logic               msb;
  logic               accept;
  logic               frame_active;
  logic [NIB_W-1:0]   csum;
  logic [FRAME_W-1:0] frame;

  framer_pacer #(.HOLD(HOLD)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick)
  );

  framer_csum #(.DATA_W(DATA_W), .NIB_W(NIB_W), .PREAMBLE(PREAMBLE)) u_csum (
    .data (pay_data),
    .sum  (csum)
  );

  assign frame = {PREAMBLE, pay_data, csum};

  framer_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .load     (accept),
    .frame_in (frame),
    .msb      (msb),
    .last_bit (last_bit)
  );

  assign frame_active = (state == FR_SEND);
  assign pay_ready    = bit_tick && (!frame_active || last_bit);
  assign accept       = pay_ready && pay_valid;
  assign bit_out      = frame_active && msb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= FR_IDLE;
    end else if (accept) begin
      state <= FR_SEND;
    end else if (bit_tick && last_bit) begin
      state <= FR_IDLE;
    end
  end
endmodule

// File: rtl/framer_chk.sv
module framer_chk (
  input logic clk,
  input logic rst_n,
  input logic pay_valid,
  input logic pay_ready,
  input logic bit_out,
  input logic bit_tick,
  input logic frame_active
);
  a_r5_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> bit_tick);

  a_r4_hold_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(bit_out));

  a_r6_preamble_leads: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && pay_ready) |=> (bit_out && frame_active));

  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !bit_out);

  a_r9_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !frame_active && !pay_valid) |=> !frame_active);
endmodule

bind pkt_framer_ser framer_chk u_framer_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pay_valid    (pay_valid),
  .pay_ready    (pay_ready),
  .bit_out      (bit_out),
  .bit_tick     (bit_tick),
  .frame_active (frame_active)
);

// File: tb/test_pkt_framer_ser.sv
module test_pkt_framer_ser;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 8;
  localparam int FW         = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pay_data = '0;
  logic        pay_valid = 1'b0;
  logic        pay_ready;
  logic        bit_out;

  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  int b2b_seen = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [23:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_framer_ser i_pkt_framer_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .pay_data  (pay_data),
    .pay_valid (pay_valid),
    .pay_ready (pay_ready),
    .bit_out   (bit_out)
  );

  function automatic logic [23:0] model_frame(input logic [15:0] d);
    int s = 15;
    for (int i = 0; i < 4; i++) s += int'((d >> (4 * i)) & 16'hF);
    return {4'hF, d, 4'(s % 16)};
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: called at posedge+1; returns one cycle after the taking edge.
  task automatic send(input logic [15:0] d);
    exp_q.push_back(model_frame(d));
    pay_data  = d;
    pay_valid = 1'b1;
    while (!pay_ready) begin
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
  endtask

  always @(posedge clk) if (rst_n) cyc++;

  // R4/R5: ready only on the 8-cycle grid.
  always @(negedge clk) begin
    if (rst_n && pay_ready) chk((cyc % HOLD) == HOLD - 1, "R5 ready grid", cyc % HOLD, HOLD - 1);
  end

  // Monitor / scoreboard.
  initial begin
    bit hs;
    wait (rst_n);
    forever begin
      @(negedge clk);
      hs = pay_valid && pay_ready;
      if (!hs) chk(bit_out == 1'b0, "R7 idle line", bit_out, 0);
      while (hs) begin
        logic [23:0] got;
        logic [23:0] exp;
        int bad_hold = 0;
        got = '0;
        for (int b = 0; b < FW; b++) begin
          logic first = 1'b0;
          for (int k = 0; k < HOLD; k++) begin
            @(negedge clk);
            if (k == 0) first = bit_out;
            else if (bit_out !== first) bad_hold++;
          end
          got = {got[22:0], first};
        end
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : 24'hxxxxxx;
        frames_seen++;
        chk(got === exp, "R1 R2 R3 frame", got, exp);
        chk(bad_hold == 0, "R4 bit hold", bad_hold, 0);
        hs = pay_valid && pay_ready;
        if (hs) b2b_seen++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(bit_out == 1'b0, "R8 reset bit_out", bit_out, 0);
    chk(pay_ready == 1'b0, "R8 reset ready", pay_ready, 0);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    #1;

    // R9: offer and withdraw before ready rises.
    while (!pay_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    pay_data  = 16'hA5A5;
    pay_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    pay_valid = 1'b0;
    repeat (30) @(posedge clk);
    #1;
    chk(frames_seen == 0, "R9 withdrawn word", frames_seen, 0);
    chk(bit_out == 1'b0, "R9 line low", bit_out, 0);

    // Single frame: all-zero payload, checksum 4'hF.
    send(16'h0000);
    pay_valid = 1'b0;
    repeat (220) @(posedge clk);
    #1;
    chk(frames_seen == 1, "R6 single frame", frames_seen, 1);

    // Back-to-back burst, including carry-dropping sums.
    send(16'hFFFF);
    send(16'h5D39);
    send(16'h1234);
    send(16'h8001);
    pay_valid = 1'b0;
    repeat (220) @(posedge clk);
    #1;
    chk(frames_seen == 5, "R6 frame count", frames_seen, 5);
    chk(b2b_seen == 3, "R6 gapless joins", b2b_seen, 3);
    chk(exp_q.size() == 0, "R5 all words taken", exp_q.size(), 0);
    chk(model_frame(16'hFFFF) == 24'hFFFFFB, "R2 model carry", model_frame(16'hFFFF), 24'hFFFFFB);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule